// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Receiver

This block receives Bulk and Interrupt OUT data packets for a single USB device endpoint and hands them to a CPU. Its inputs are packet events that have already been decoded: an OUT token addressed to this endpoint, data bytes with a valid strobe, the data PID (DATA0 or DATA1), and an end-of-packet strobe that carries a CRC-good indication. Payload bytes go into a small endpoint FIFO while the block counts every byte the host sends. One cycle after the end of the packet the block chooses the handshake to return.

When a good packet is accepted, a receive-complete flag is set. If interrupts are enabled, the flag also drives the interrupt line. The CPU reads the 16-bit byte count as a low byte and a high byte, pops the FIFO one byte per read strobe, and then clears the flag. While the flag is set, the endpoint refuses further data with NAK. The block also tracks the expected data toggle, so a retransmitted packet is acknowledged but not delivered a second time.

Top module: `usb_out_ep_rx`

## Requirements
- R1: While `ep_enable` and `ep_config` are not both high, OUT traffic gets no handshake (`hs_code` 00) and the flag, the count and the FIFO do not change.
- R2: An accepted packet with good CRC and the expected toggle is answered with ACK (`hs_code` 01) and sets `rx_done`. `irq` equals `rx_done` while `irq_en` is high and is low otherwise.
- R3: The count of the last accepted packet reads as `{cnt_hi, cnt_lo}`. Its stored bytes are read from `rd_data` in the order they arrived.
- R4: A zero-length packet is ACKed and sets `rx_done`. The count reads 0 and the FIFO stays empty.
- R5: If `rx_done` is high when the OUT token arrives, the packet gets NAK (`hs_code` 10). Its bytes are not stored, and the count and `rx_done` do not change.
- R6: A `cpu_clr` pulse while `rx_done` is high clears the flag and empties the FIFO. The next good packet is ACKed.
- R7: If a packet is longer than DEPTH bytes, the first DEPTH bytes are stored and the rest are dropped. With good CRC the packet is still ACKed, and the count reports the full length the host sent.
- R8: The byte count saturates at 0xFFFF.
- R9: A packet with `rx_crc_ok` low at end of packet gets no handshake. The flag, the count and the toggle do not change, and any bytes it wrote are removed from the FIFO.
- R10: The expected toggle is DATA0 (`rx_pid1` 0) whenever the endpoint is not both enabled and configured. Each delivered packet flips it. A packet with the wrong toggle is ACKed but discarded: the flag, the count and the toggle stay as they were.
- R11: The handshake code appears in the cycle after the cycle with `rx_eop` high and lasts one cycle. Codes: 00 none, 01 ACK, 10 NAK.
- R12: Each `cpu_rd` cycle pops one byte. When the FIFO is empty, `rd_data` is 0 and a read does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ep_enable | input | 1 | Endpoint enabled |
| ep_config | input | 1 | Endpoint configured |
| irq_en | input | 1 | Interrupt enable |
| tok_out | input | 1 | OUT token for this endpoint (one cycle) |
| rx_valid | input | 1 | Data byte strobe (ignored in the `rx_eop` cycle) |
| rx_byte | input | 8 | Data byte |
| rx_pid1 | input | 1 | Data PID, 1 = DATA1, sampled with `rx_eop` |
| rx_eop | input | 1 | End of data packet |
| rx_crc_ok | input | 1 | CRC good, sampled with `rx_eop` |
| cpu_rd | input | 1 | Pop one FIFO byte |
| cpu_clr | input | 1 | Clear the receive-complete flag |
| hs_code | output | 2 | Handshake: 00 none, 01 ACK, 10 NAK |
| rx_done | output | 1 | Receive-complete flag |
| irq | output | 1 | Interrupt |
| cnt_lo | output | 8 | Byte count, bits 7:0 |
| cnt_hi | output | 8 | Byte count, bits 15:8 |
| rd_data | output | 8 | FIFO head byte, 0 when empty |

## Verification
The main function is exercised with several packet shapes:
- **Short packets:** a short packet and a zero-length packet show whether the count and the FIFO move together.
- **Long packets:** a packet longer than the FIFO separates the stored length from the counted length, and a 65,540-byte packet exposes whether the counter wraps.
- **Flag and endpoint state:** packets sent while the flag is set, and while the endpoint is unconfigured, tell NAK apart from silence.
- **Bad CRC and toggle:** a bad-CRC packet and a repeated-toggle packet each separate "ACKed" from "delivered". Reconfiguring the endpoint between packets checks that the toggle returns to DATA0.

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ep_enable,
  input  logic       ep_config,
  input  logic       irq_en,
  input  logic       tok_out,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_pid1,
  input  logic       rx_eop,
  input  logic       rx_crc_ok,
  input  logic       cpu_rd,
  input  logic       cpu_clr,
  output logic [1:0] hs_code,
  output logic       rx_done,
  output logic       irq,
  output logic [7:0] cnt_lo,
  output logic [7:0] cnt_hi,
  output logic [7:0] rd_data
);
  localparam int AW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] HS_NONE = 2'b00, HS_ACK = 2'b01, HS_NAK = 2'b10;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [15:0]   len, cnt;
  logic          active, acc, tog;

  wire ep_on  = ep_enable & ep_config;
  wire empty  = (rd_ptr == wr_ptr);
  wire in_pkt = ep_on & ~tok_out & active & ~rx_eop;
  wire wr_en  = in_pkt & rx_valid & acc & (wr_ptr < AW'(DEPTH));

  assign irq     = rx_done & irq_en;
  assign cnt_lo  = cnt[7:0];
  assign cnt_hi  = cnt[15:8];
  assign rd_data = empty ? 8'h00 : mem[rd_ptr[IW-1:0]];

  always_ff @(posedge clk)
    if (wr_en) mem[wr_ptr[IW-1:0]] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_code <= HS_NONE;
      rx_done <= 1'b0;
      active  <= 1'b0;
      acc     <= 1'b0;
      tog     <= 1'b0;
      len     <= '0;
      cnt     <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
    end else begin
      hs_code <= HS_NONE;
      if (!ep_on) begin
        active <= 1'b0;
        tog    <= 1'b0;
      end else if (tok_out) begin
        active <= 1'b1;
        acc    <= ~rx_done;
        len    <= '0;
        if (!rx_done) begin
          wr_ptr <= '0;
          rd_ptr <= '0;
        end
      end else if (active && rx_eop) begin
        active <= 1'b0;
        if (rx_crc_ok) begin
          if (!acc) hs_code <= HS_NAK;
          else begin
            hs_code <= HS_ACK;
            if (rx_pid1 == tog) begin
              rx_done <= 1'b1;
              cnt     <= len;
              tog     <= ~tog;
            end else wr_ptr <= '0;
          end
        end else if (acc) wr_ptr <= '0;
      end else if (active && rx_valid) begin
        if (len != 16'hFFFF) len <= len + 16'd1;
        if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      end
      if (cpu_rd && !empty) rd_ptr <= rd_ptr + AW'(1);
      if (cpu_clr && rx_done) begin
        rx_done <= 1'b0;
        wr_ptr  <= '0;
        rd_ptr  <= '0;
      end
    end
  end

  assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ep_on) |-> hs_code == HS_NONE);

  assert_flag_by_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> hs_code == HS_ACK);

  assert_nak_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_code == HS_NAK |-> (cnt == $past(cnt)) && rx_done);

  assert_hs_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hs_code != HS_NONE |=> hs_code == HS_NONE);

  assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> rd_data == 8'h00);
endmodule

// File: tb/usb_out_ep_rx_test.sv
module usb_out_ep_rx_test;
  logic clk = 0, rst_n = 0;
  logic ep_enable = 1, ep_config = 0, irq_en = 1, tok_out = 0, rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic rx_pid1 = 0, rx_eop = 0, rx_crc_ok = 0, cpu_rd = 0, cpu_clr = 0;
  logic [1:0] hs_code;
  logic rx_done, irq;
  logic [7:0] cnt_lo, cnt_hi, rd_data;
  logic eop_d = 0;
  logic [1:0] exp_q[$];
  int n_cmp = 0, n_bad = 0;

  usb_out_ep_rx #(.DEPTH(64)) uut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) eop_d <= rx_eop;

  always @(negedge clk)
    if (eop_d) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R11 handshake: actual %0d expected nothing queued", hs_code);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        if (hs_code !== e) begin
          n_bad++;
          $display("FAIL R11 handshake: actual %0d expected %0d", hs_code, e);
        end
      end
    end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pkt(input int n, input bit pid, input bit crc, input logic [7:0] seed,
                     input logic [1:0] exp);
    exp_q.push_back(exp);
    @(negedge clk) tok_out = 1;
    @(negedge clk) tok_out = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_byte = seed + 8'(i);
      @(negedge clk);
    end
    rx_valid = 0; rx_pid1 = pid; rx_crc_ok = crc; rx_eop = 1;
    @(negedge clk) rx_eop = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    check({8'h0, rd_data}, {8'h0, exp}, tag);
    cpu_rd = 1;
    @(negedge clk) cpu_rd = 0;
  endtask

  task automatic clr;
    cpu_clr = 1;
    @(negedge clk) cpu_clr = 0;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({14'h0, hs_code}, 0, "reset hs_code");
    check({15'h0, rx_done}, 0, "reset rx_done");
    check({cnt_hi, cnt_lo}, 0, "reset count");
    check({8'h0, rd_data}, 0, "reset rd_data");

    // R1: endpoint enabled but unconfigured
    pkt(3, 0, 1, 8'h10, 2'b00);
    check({15'h0, rx_done}, 0, "R1 flag");
    check({cnt_hi, cnt_lo}, 0, "R1 count");
    ep_config = 1;

    // R2/R3/R12: normal packet
    pkt(4, 0, 1, 8'hA0, 2'b01);
    check({15'h0, rx_done}, 1, "R2 flag");
    check({15'h0, irq}, 1, "R2 irq");
    check({cnt_hi, cnt_lo}, 4, "R3 count");
    for (int i = 0; i < 4; i++) rd(8'hA0 + 8'(i), "R3 data order");
    rd(8'h00, "R12 empty read");
    rd(8'h00, "R12 empty read again");
    irq_en = 0;
    @(negedge clk);
    check({15'h0, irq}, 0, "R2 irq disabled");
    irq_en = 1;

    // R5: NAK while flag set
    pkt(5, 1, 1, 8'h55, 2'b10);
    check({cnt_hi, cnt_lo}, 4, "R5 count held");
    check({8'h0, rd_data}, 0, "R5 nothing stored");

    // R6: clear then accept
    clr();
    check({15'h0, rx_done}, 0, "R6 flag cleared");
    pkt(5, 1, 1, 8'h30, 2'b01);
    check({cnt_hi, cnt_lo}, 5, "R6 count");
    rd(8'h30, "R6 first byte");
    clr();

    // R4: zero-length packet
    pkt(0, 0, 1, 8'h00, 2'b01);
    check({15'h0, rx_done}, 1, "R4 flag");
    check({cnt_hi, cnt_lo}, 0, "R4 count");
    check({8'h0, rd_data}, 0, "R4 fifo empty");
    clr();

    // R9: bad CRC
    pkt(3, 1, 0, 8'h77, 2'b00);
    check({15'h0, rx_done}, 0, "R9 flag");
    check({cnt_hi, cnt_lo}, 0, "R9 count");
    check({8'h0, rd_data}, 0, "R9 fifo rolled back");

    // R10: wrong toggle (expecting DATA1), then right one
    pkt(3, 0, 1, 8'h90, 2'b01);
    check({15'h0, rx_done}, 0, "R10 repeat not delivered");
    check({8'h0, rd_data}, 0, "R10 repeat not stored");
    pkt(2, 1, 1, 8'hC0, 2'b01);
    check({15'h0, rx_done}, 1, "R10 toggle kept");
    check({cnt_hi, cnt_lo}, 2, "R10 count");
    clr();

    // R7: overflow (expecting DATA0)
    pkt(70, 0, 1, 8'h00, 2'b01);
    check({cnt_hi, cnt_lo}, 70, "R7 full count");
    for (int i = 0; i < 64; i++) rd(8'(i), "R7 stored byte");
    rd(8'h00, "R7 excess dropped");
    clr();

    // R10: reconfigure resets toggle to DATA0
    ep_config = 0;
    @(negedge clk) ep_config = 1;
    pkt(1, 0, 1, 8'hEE, 2'b01);
    check({15'h0, rx_done}, 1, "R10 toggle reset");
    clr();

    // R8: saturation (expecting DATA1)
    pkt(65540, 1, 1, 8'h00, 2'b01);
    check({cnt_hi, cnt_lo}, 16'hFFFF, "R8 saturated count");
    clr();

    repeat (3) @(negedge clk);
    check(16'(exp_q.size()), 0, "R11 all handshakes seen");
    report();
  end
endmodule